// File: doc/BRIEF.md
# Isochronous Cycle Event Monitor

This block watches the free-running bus cycle timer and the bus-idle detector of a serial bus link. From them it derives the status events of the isochronous cycle. It flags each new cycle as pending when the cycle-offset field returns to zero. It reports the start and the end of the cycle. It notices when two cycle periods go by without a cycle start arriving. It reports when the second field of the timer advances. Each event is a one-clock pulse that a later interrupt collector can latch.

The block also guards the cycle-master role. It counts microsecond ticks from the start of each cycle to the fair gap that ends it. If a cycle overruns the budget, it raises a timeout event and a sticky request that turns off cycle mastering. That request holds until software turns the master enable off and then on again. The cycle timer, the packet engines and the interrupt registers sit outside this block.

All outputs are registered. Each event appears on the clock edge that samples its cause. The asynchronous active-low reset is released synchronously, two clocks after the reset pin goes high.

Top module: `iso_cycle_watch`

## Requirements
- R1: `cyc_pending` goes high one clock after the offset input is sampled as zero, when the sample before it was non-zero. The first zero sample after reset also counts. The flag stays high until R4 clears it.
- R2: `evt_start` pulses for one clock, one clock after `cs_sent` or `cs_rcvd` is sampled high.
- R3: `evt_done` pulses one clock after the first `fair_gap` that follows a cycle start. Further fair gaps before the next cycle start are ignored. A fair gap sampled in the same clock as a cycle start is also ignored.
- R4: `cyc_pending` clears in the clock that `evt_done` rises. If a new offset zero (R1) is sampled in that same clock, the set wins.
- R5: `evt_lost` pulses one clock after the second offset zero (R1 sense) that has no `cs_rcvd` since the previous count clear. Counts clear on `cs_rcvd`, after each lost event, and in every clock `master_en` is high. While `master_en` is high, no lost event fires.
- R6: Counting starts at a cycle start. Each `us_tick` counts while the cycle is open, except a tick in the same clock as `fair_gap`. On the tick that makes the count exceed OVERRUN_US (126 ticks by default), `evt_timeout` pulses one clock later. It fires at most once per cycle.
- R7: `master_off` rises together with `evt_timeout`. It stays high until `master_en` is sampled high after having been sampled low. A rising edge and a new timeout in the same clock leave it high.
- R8: `evt_second` pulses one clock after the second input is sampled equal to its previous sample plus one, modulo 2^SEC_W (127 to 0 counts). Any other change of the field gives no pulse.
- R9: While reset is asserted, every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_offset | input | OFS_W (12) | Cycle-offset field of the cycle timer |
| cyc_second | input | SEC_W (7) | Second field of the cycle timer |
| cs_sent | input | 1 | Pulse: a cycle start packet was transmitted |
| cs_rcvd | input | 1 | Pulse: a cycle start packet was received |
| fair_gap | input | 1 | Pulse: bus idle for a fair gap |
| master_en | input | 1 | Level: this node acts as cycle master |
| us_tick | input | 1 | Pulse: one microsecond has elapsed |
| evt_start | output | 1 | Cycle started event |
| evt_done | output | 1 | Cycle done event |
| evt_lost | output | 1 | Cycle lost event |
| evt_timeout | output | 1 | Cycle overrun event |
| evt_second | output | 1 | Cycle-second increment event |
| cyc_pending | output | 1 | Level: cycle pending |
| master_off | output | 1 | Sticky request to disable cycle mastering |

## Verification
The assertions assume that every input is synchronous to `clk`. They also assume that the pulse inputs are already single-clock events, with edges seen once per sample. Nothing is assumed about how cycle starts, fair gaps and offset zeros are spaced. The stimulus therefore changes inputs only on falling edges and builds offset zeros from a wrapping counter. Besides the directed sequences, it mixes in pseudo-random overlaps: a start together with a gap, a gap with a tick, and a zero with a receive. Every ordering corner in R3 to R7 is reached this way without leaving synchronous single-clock pulses.

// File: rtl/iso_cyc_pkg.sv
package iso_cyc_pkg;
  localparam int unsigned DEF_OFS_W      = 12;
  localparam int unsigned DEF_SEC_W      = 7;
  localparam int unsigned DEF_OVERRUN_US = 125;
  localparam int unsigned DEF_LOST_ROLLS = 2;

  typedef struct packed {
    logic start;
    logic done;
    logic lost;
    logic timeout;
    logic second;
  } cyc_evt_t;
endpackage

// File: rtl/iso_cyc_phase.sv
module iso_cyc_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_sent_i,
  input  logic cs_rcvd_i,
  input  logic fair_gap_i,
  input  logic zero_hit_i,
  output logic start_o,
  output logic done_o,
  output logic pending_o,
  output logic active_o
);
  logic cs_any;
  logic start_d, done_d, pending_d, active_d;
  logic active_q;

  assign cs_any = cs_sent_i | cs_rcvd_i;

  always_comb begin
    start_d   = cs_any;
    done_d    = fair_gap_i & active_q & ~cs_any;
    active_d  = active_q;
    if (cs_any)          active_d = 1'b1;
    else if (fair_gap_i) active_d = 1'b0;
    pending_d = pending_o;
    if (zero_hit_i)  pending_d = 1'b1;
    else if (done_d) pending_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o   <= 1'b0;
      done_o    <= 1'b0;
      pending_o <= 1'b0;
      active_q  <= 1'b0;
    end else begin
      start_o   <= start_d;
      done_o    <= done_d;
      pending_o <= pending_d;
      active_q  <= active_d;
    end
  end

  assign active_o = active_q;

  assert_start_follows_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(cs_sent_i | cs_rcvd_i));

  assert_done_not_with_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !start_o);

  assert_done_clears_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(zero_hit_i)) |-> !pending_o);
endmodule

// File: rtl/iso_cyc_lost.sv
module iso_cyc_lost #(
  parameter int unsigned ROLLS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zero_hit_i,
  input  logic cs_rcvd_i,
  input  logic master_en_i,
  output logic lost_o
);
  localparam int unsigned CW = (ROLLS > 1) ? $clog2(ROLLS) : 1;
  localparam logic [CW-1:0] LAST = CW'(ROLLS - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          lost_d;

  always_comb begin
    cnt_d  = cnt_q;
    lost_d = 1'b0;
    if (master_en_i || cs_rcvd_i) begin
      cnt_d = '0;
    end else if (zero_hit_i) begin
      if (cnt_q == LAST) begin
        lost_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      lost_o <= lost_d;
    end
  end

  assert_lost_not_master_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> !$past(master_en_i));

  assert_lost_needs_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lost_o |-> $past(zero_hit_i) && !$past(cs_rcvd_i));
endmodule

// File: rtl/iso_cyc_overrun.sv
module iso_cyc_overrun #(
  parameter int unsigned LIMIT = 125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_i,
  input  logic active_i,
  input  logic fair_gap_i,
  input  logic us_tick_i,
  input  logic master_en_i,
  output logic timeout_o,
  output logic master_off_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          fired_q, fired_d;
  logic          me_q;
  logic          timeout_d, master_off_d, me_rise;

  always_comb begin
    cnt_d     = cnt_q;
    fired_d   = fired_q;
    timeout_d = 1'b0;
    if (cs_i) begin
      cnt_d   = '0;
      fired_d = 1'b0;
    end else if (active_i && us_tick_i && !fair_gap_i && !fired_q) begin
      if (cnt_q == LIM) begin
        timeout_d = 1'b1;
        fired_d   = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    me_rise      = master_en_i & ~me_q;
    master_off_d = master_off_o;
    if (timeout_d)    master_off_d = 1'b1;
    else if (me_rise) master_off_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q        <= '0;
      fired_q      <= 1'b0;
      me_q         <= 1'b0;
      timeout_o    <= 1'b0;
      master_off_o <= 1'b0;
    end else begin
      cnt_q        <= cnt_d;
      fired_q      <= fired_d;
      me_q         <= master_en_i;
      timeout_o    <= timeout_d;
      master_off_o <= master_off_d;
    end
  end

  assert_timeout_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);

  assert_timeout_sets_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> master_off_o);

  assert_off_clears_on_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master_off_o) |-> $past(master_en_i));
endmodule

// File: rtl/iso_cyc_second.sv
module iso_cyc_second #(
  parameter int unsigned SEC_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] second_i,
  output logic             second_o
);
  logic [SEC_W-1:0] prev_q;
  logic             valid_q;
  logic             step_d;

  always_comb begin
    step_d = valid_q && (second_i == SEC_W'(prev_q + 1'b1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      valid_q  <= 1'b0;
      second_o <= 1'b0;
    end else begin
      prev_q   <= second_i;
      valid_q  <= 1'b1;
      second_o <= step_d;
    end
  end

  assert_second_on_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
    second_o |-> $past(second_i) != $past(second_i, 2));
endmodule

// File: rtl/iso_cycle_watch.sv
module iso_cycle_watch #(
  parameter int unsigned OFS_W      = iso_cyc_pkg::DEF_OFS_W,
  parameter int unsigned SEC_W      = iso_cyc_pkg::DEF_SEC_W,
  parameter int unsigned OVERRUN_US = iso_cyc_pkg::DEF_OVERRUN_US,
  parameter int unsigned LOST_ROLLS = iso_cyc_pkg::DEF_LOST_ROLLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] cyc_offset,
  input  logic [SEC_W-1:0] cyc_second,
  input  logic             cs_sent,
  input  logic             cs_rcvd,
  input  logic             fair_gap,
  input  logic             master_en,
  input  logic             us_tick,
  output logic             evt_start,
  output logic             evt_done,
  output logic             evt_lost,
  output logic             evt_timeout,
  output logic             evt_second,
  output logic             cyc_pending,
  output logic             master_off
);
  import iso_cyc_pkg::*;

  localparam int unsigned SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;
  logic                   nonzero_q, nonzero_d;
  logic                   zero_hit;
  logic                   active;
  cyc_evt_t               evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  always_comb begin
    nonzero_d = |cyc_offset;
    zero_hit  = ~nonzero_d & nonzero_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) nonzero_q <= 1'b1;
    else            nonzero_q <= nonzero_d;
  end

  iso_cyc_phase u_phase (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .cs_sent_i  (cs_sent),
    .cs_rcvd_i  (cs_rcvd),
    .fair_gap_i (fair_gap),
    .zero_hit_i (zero_hit),
    .start_o    (evt.start),
    .done_o     (evt.done),
    .pending_o  (cyc_pending),
    .active_o   (active)
  );

  iso_cyc_lost #(.ROLLS(LOST_ROLLS)) u_lost (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .zero_hit_i  (zero_hit),
    .cs_rcvd_i   (cs_rcvd),
    .master_en_i (master_en),
    .lost_o      (evt.lost)
  );

  iso_cyc_overrun #(.LIMIT(OVERRUN_US)) u_overrun (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .cs_i         (cs_sent | cs_rcvd),
    .active_i     (active),
    .fair_gap_i   (fair_gap),
    .us_tick_i    (us_tick),
    .master_en_i  (master_en),
    .timeout_o    (evt.timeout),
    .master_off_o (master_off)
  );

  iso_cyc_second #(.SEC_W(SEC_W)) u_second (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .second_i (cyc_second),
    .second_o (evt.second)
  );

  assign evt_start   = evt.start;
  assign evt_done    = evt.done;
  assign evt_lost    = evt.lost;
  assign evt_timeout = evt.timeout;
  assign evt_second  = evt.second;

  assert_pending_set_on_zero_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(cyc_pending) |-> $past(cyc_offset) == '0);

  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> !(evt_start | evt_done | evt_lost | evt_timeout | evt_second | cyc_pending | master_off));
endmodule

// File: tb/iso_cycle_watch_test.sv
module iso_cycle_watch_test;
  localparam int CLK_PERIOD = 10;
  localparam int OFS_W = 12;
  localparam int SEC_W = 7;
  localparam int LIMIT = 125;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OFS_W-1:0] cyc_offset = 12'd5;
  logic [SEC_W-1:0] cyc_second = 7'd3;
  logic cs_sent = 0, cs_rcvd = 0, fair_gap = 0, master_en = 0, us_tick = 0;
  logic evt_start, evt_done, evt_lost, evt_timeout, evt_second, cyc_pending, master_off;

  int vectors = 0, errors = 0;
  bit done_flag = 0;
  bit ofs_run = 0;
  int period = 20;
  logic [31:0] rs = 32'h1234_5678;

  always #(CLK_PERIOD/2) clk = ~clk;

  iso_cycle_watch uut (
    .clk(clk), .rst_n(rst_n), .cyc_offset(cyc_offset), .cyc_second(cyc_second),
    .cs_sent(cs_sent), .cs_rcvd(cs_rcvd), .fair_gap(fair_gap), .master_en(master_en),
    .us_tick(us_tick), .evt_start(evt_start), .evt_done(evt_done), .evt_lost(evt_lost),
    .evt_timeout(evt_timeout), .evt_second(evt_second), .cyc_pending(cyc_pending),
    .master_off(master_off)
  );

  // behavioural reference
  int  m_lcnt, m_tcnt, m_prevsec;
  bit  m_prevnz, m_open, m_fired, m_prevme, m_secval;
  bit  e_start, e_done, e_lost, e_to, e_sec, e_pend, e_off;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lcnt = 0; m_tcnt = 0; m_prevsec = 0;
      m_prevnz = 1; m_open = 0; m_fired = 0; m_prevme = 0; m_secval = 0;
      e_start = 0; e_done = 0; e_lost = 0; e_to = 0; e_sec = 0; e_pend = 0; e_off = 0;
    end else begin
      bit zh, cs, was_open;
      zh = (cyc_offset == 0) && m_prevnz;
      cs = cs_sent || cs_rcvd;
      was_open = m_open;
      e_start = cs;
      e_done = fair_gap && was_open && !cs;
      if (cs) m_open = 1; else if (fair_gap) m_open = 0;
      if (zh) e_pend = 1; else if (e_done) e_pend = 0;
      e_lost = 0;
      if (master_en || cs_rcvd) m_lcnt = 0;
      else if (zh) begin
        m_lcnt++;
        if (m_lcnt == 2) begin e_lost = 1; m_lcnt = 0; end
      end
      e_to = 0;
      if (cs) begin m_tcnt = 0; m_fired = 0; end
      else if (was_open && us_tick && !fair_gap && !m_fired) begin
        m_tcnt++;
        if (m_tcnt == LIMIT + 1) begin e_to = 1; m_fired = 1; end
      end
      if (e_to) e_off = 1; else if (master_en && !m_prevme) e_off = 0;
      m_prevme = master_en;
      e_sec = m_secval && (cyc_second == ((m_prevsec + 1) % (1 << SEC_W)));
      m_prevsec = cyc_second;
      m_secval = 1;
      m_prevnz = (cyc_offset != 0);
    end
  end

  task automatic chk(input string tag, input logic act, input bit exp);
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done_flag) begin
      vectors++;
      if (!rst_n) begin
        chk("R9 reset evt_start", evt_start, 0);
        chk("R9 reset evt_done", evt_done, 0);
        chk("R9 reset evt_lost", evt_lost, 0);
        chk("R9 reset evt_timeout", evt_timeout, 0);
        chk("R9 reset evt_second", evt_second, 0);
        chk("R9 reset cyc_pending", cyc_pending, 0);
        chk("R9 reset master_off", master_off, 0);
      end else begin
        chk("R2 evt_start", evt_start, e_start);
        chk("R3 evt_done", evt_done, e_done);
        chk("R1/R4 cyc_pending", cyc_pending, e_pend);
        chk("R5 evt_lost", evt_lost, e_lost);
        chk("R6 evt_timeout", evt_timeout, e_to);
        chk("R7 master_off", master_off, e_off);
        chk("R8 evt_second", evt_second, e_sec);
      end
    end
  end

  function automatic int rnd(input int n);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return int'(rs % n);
  endfunction

  task automatic adv();
    @(negedge clk);
    cs_sent = 0; cs_rcvd = 0; fair_gap = 0; us_tick = 0;
    if (ofs_run) begin
      if (cyc_offset >= OFS_W'(period - 1)) cyc_offset = '0;
      else cyc_offset = cyc_offset + 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) adv();
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    idle(5);                       // R9 checked during reset
    rst_n = 1;
    idle(5);
    // R1, R5: rollovers with no cycle start
    ofs_run = 1; period = 20;
    idle(70);
    // R5: suppressed while master
    master_en = 1;
    idle(70);
    master_en = 0;
    // R2, R3, R4: regular received cycles, extra gap ignored
    for (int i = 0; i < 200; i++) begin
      adv();
      us_tick = 1;
      if (cyc_offset == 2) cs_rcvd = 1;
      if (cyc_offset == 8 || cyc_offset == 12) fair_gap = 1;
    end
    // R6, R7: overrun with master enabled
    ofs_run = 0;
    adv(); cyc_offset = 7; master_en = 1;
    adv(); cs_sent = 1;
    for (int i = 0; i < 140; i++) begin adv(); us_tick = 1; end
    adv(); fair_gap = 1;
    idle(5);
    master_en = 0; idle(3);
    master_en = 1; idle(5);
    // R6: tick in gap cycle not counted; exact boundary
    adv(); cs_sent = 1;
    for (int i = 0; i < LIMIT; i++) begin adv(); us_tick = 1; end
    adv(); us_tick = 1; fair_gap = 1;
    idle(4);
    // R8: second field steps, jumps and wraps
    adv(); cyc_second = 10; idle(2);
    cyc_second = 11; idle(2);
    cyc_second = 13; idle(2);
    cyc_second = 14; idle(2);
    cyc_second = 127; idle(2);
    cyc_second = 0; idle(3);
    // R3: start and gap together
    adv(); cs_rcvd = 1; fair_gap = 1;
    idle(3); fair_gap = 1; idle(3);
    // mixed pseudo-random traffic
    master_en = 0; ofs_run = 1;
    for (int i = 0; i < 4000; i++) begin
      adv();
      if (cyc_offset == 0) period = 6 + rnd(30);
      cs_rcvd  = (rnd(12) == 0);
      cs_sent  = (rnd(20) == 0);
      fair_gap = (rnd(6) == 0);
      us_tick  = (rnd(2) == 0);
      if (rnd(60) == 0) master_en = ~master_en;
      if (rnd(25) == 0) cyc_second = cyc_second + SEC_W'(1 + (rnd(4) == 0 ? 1 : 0));
    end
    idle(3);
    finish_run();
  end
endmodule